// File: doc/BRIEF.md
# Lockstep Mismatch Reconfiguration Sequencer

This block watches two processors that run the same program in lockstep and compares their output words on every clock. While the words agree, the block reports normal running and leaves the current hardware configuration alone. When they disagree, it stops normal running and starts a search for a working configuration. Each configuration is a choice among three pairs of redundant units: which processor is active, which bus copy is used, and which memory copy is used. That gives eight combinations.

For each candidate combination the block drives the three select lines and launches an external sanity test with a single-cycle start pulse. It then waits for a pass or a fail, with a programmable timeout. The first combination that passes becomes the running configuration. For a settable number of cycles after that, compare results are ignored, so that the switchover does not cause a false mismatch. If all eight combinations fail, the block raises an alarm and stays isolated until an operator restart arrives.

Top module: `lockstep_reconfig_seq`

## Requirements
- R1: After a synchronous active-low reset, seq_state is 0 (run), combo_idx is 0, all three selects are 0, run_en is 1, and sanity_start and all_failed are 0.
- R2: In run state with the blanking counter at zero, unequal cpu_a_out and cpu_b_out cause seq_state to become 1 (launch) and run_en to drop on the next cycle.
- R3: The selects {sel_mem, sel_bus, sel_cpu} equal the Gray code of combo_idx (p ^ (p >> 1)). Every new trial advances combo_idx by one modulo 8, so exactly one select changes per trial.
- R4: sanity_start is high only in launch state and for exactly one cycle per trial. The state that follows is 2 (wait).
- R5: In wait state, sanity_pass returns the block to run state on the next cycle with the selects unchanged. A pass takes priority over a fail that arrives in the same cycle.
- R6: In wait state, sanity_fail, or timeout_cycles wait cycles with no response (a value of 0 acts as 1), moves the block to the next combination in launch state.
- R7: A failure on the eighth consecutive trial puts the block in state 3 (isolate) with all_failed high, with combo_idx back at the combination that was running when the mismatch hit.
- R8: Isolate state holds until manual_restart. A restart clears all_failed and begins a fresh round of up to eight trials at the next combination.
- R9: After a pass, mismatches are ignored for the first blank_cycles cycles in run state. A mismatch in the cycle after that is acted on.
- R10: Mismatches outside run state have no effect, and manual_restart outside isolate state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_a_out | input | DW | Output word of processor copy A |
| cpu_b_out | input | DW | Output word of processor copy B |
| timeout_cycles | input | TMO_W | Wait limit per sanity trial |
| blank_cycles | input | BLANK_W | Compare blanking length after a pass |
| sanity_pass | input | 1 | Sanity test passed |
| sanity_fail | input | 1 | Sanity test failed |
| manual_restart | input | 1 | Operator restart out of isolation |
| run_en | output | 1 | Normal operation allowed |
| sanity_start | output | 1 | Single-cycle sanity test launch |
| sel_cpu | output | 1 | Active processor select |
| sel_bus | output | 1 | Active bus copy select |
| sel_mem | output | 1 | Active memory copy select |
| all_failed | output | 1 | All eight combinations failed |
| combo_idx | output | 3 | Position in the Gray search order |
| seq_state | output | 2 | 0 run, 1 launch, 2 wait, 3 isolate |

## Verification
The bench targets the exact length of the blanking window. A counter that is off by one lets one extra mismatch through, or swallows one, and the sequencer restarts a cycle early or late. It checks timeouts at a limit of zero and at small limits; an error here hangs the search forever or cuts trials short. It checks a pass and a fail that arrive together, which must resume running and not skip ahead. It runs a full round of eight failures, where a trial counter of the wrong width isolates too early or wraps back into the search. It also holds a mismatch and asserts a restart in states where they must do nothing.

// File: rtl/lockstep_reconfig_seq.sv
`timescale 1ns/1ps
module lockstep_reconfig_seq #(
  parameter int DW      = 32,
  parameter int TMO_W   = 16,
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DW-1:0]      cpu_a_out,
  input  logic [DW-1:0]      cpu_b_out,
  input  logic [TMO_W-1:0]   timeout_cycles,
  input  logic [BLANK_W-1:0] blank_cycles,
  input  logic               sanity_pass,
  input  logic               sanity_fail,
  input  logic               manual_restart,
  output logic               run_en,
  output logic               sanity_start,
  output logic               sel_cpu,
  output logic               sel_bus,
  output logic               sel_mem,
  output logic               all_failed,
  output logic [2:0]         combo_idx,
  output logic [1:0]         seq_state
);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_LAUNCH = 2'd1, S_WAIT = 2'd2, S_ISO = 2'd3} st_t;

  localparam logic [TMO_W-1:0]   T_ONE = {{(TMO_W-1){1'b0}}, 1'b1};
  localparam logic [BLANK_W-1:0] B_ONE = {{(BLANK_W-1){1'b0}}, 1'b1};

  st_t               st;
  logic [2:0]        pos;
  logic [3:0]        tried;
  logic [TMO_W-1:0]  tmo_cnt;
  logic [BLANK_W-1:0] blank_cnt;

  logic              mismatch;
  logic [2:0]        sel_cfg;
  logic [TMO_W-1:0]  eff_t;
  logic              expired;

  assign mismatch = cpu_a_out != cpu_b_out;
  assign sel_cfg  = pos ^ {1'b0, pos[2:1]};
  assign eff_t    = (timeout_cycles == '0) ? T_ONE : timeout_cycles;
  assign expired  = ({1'b0, tmo_cnt} + {1'b0, T_ONE}) >= {1'b0, eff_t};

  assign {sel_mem, sel_bus, sel_cpu} = sel_cfg;
  assign run_en       = st == S_RUN;
  assign sanity_start = st == S_LAUNCH;
  assign all_failed   = st == S_ISO;
  assign combo_idx    = pos;
  assign seq_state    = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_RUN;
      pos       <= 3'd0;
      tried     <= 4'd0;
      tmo_cnt   <= '0;
      blank_cnt <= '0;
    end else begin
      case (st)
        S_RUN: begin
          if (blank_cnt != '0) begin
            blank_cnt <= blank_cnt - B_ONE;
          end else if (mismatch) begin
            st    <= S_LAUNCH;
            pos   <= pos + 3'd1;
            tried <= 4'd1;
          end
        end
        S_LAUNCH: begin
          st      <= S_WAIT;
          tmo_cnt <= '0;
        end
        S_WAIT: begin
          if (sanity_pass) begin
            st        <= S_RUN;
            blank_cnt <= blank_cycles;
          end else if (sanity_fail || expired) begin
            if (tried == 4'd8) begin
              st <= S_ISO;
            end else begin
              st    <= S_LAUNCH;
              pos   <= pos + 3'd1;
              tried <= tried + 4'd1;
            end
          end else begin
            tmo_cnt <= tmo_cnt + T_ONE;
          end
        end
        default: begin
          if (manual_restart) begin
            st    <= S_LAUNCH;
            pos   <= pos + 3'd1;
            tried <= 4'd1;
          end
        end
      endcase
    end
  end

  // R2
  freeze_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && mismatch && blank_cnt == '0) |=> (!run_en && seq_state == 2'd1));

  // R3
  one_select_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sanity_start) |-> ($countones(sel_cfg ^ $past(sel_cfg)) == 1));

  // R4
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sanity_start |=> (!sanity_start && seq_state == 2'd2));

  // R5
  pass_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd2 && sanity_pass) |=> (run_en && $stable(sel_cfg)));

  // R7
  alarm_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_failed) |-> ($past(seq_state) == 2'd2 && $past(sanity_fail || expired)));

  // R8
  isolate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_failed && !manual_restart) |=> (all_failed && $stable(combo_idx)));

endmodule

// File: tb/lockstep_reconfig_seq_tb.sv
`timescale 1ns/1ps
module lockstep_reconfig_seq_tb_top;
  localparam int DW = 32, TMO_W = 16, BLANK_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] cpu_a_out = '0, cpu_b_out = '0;
  logic [TMO_W-1:0] timeout_cycles = 16'd5;
  logic [BLANK_W-1:0] blank_cycles = 8'd4;
  logic sanity_pass = 1'b0, sanity_fail = 1'b0, manual_restart = 1'b0;
  logic run_en, sanity_start, sel_cpu, sel_bus, sel_mem, all_failed;
  logic [2:0] combo_idx;
  logic [1:0] seq_state;

  lockstep_reconfig_seq #(.DW(DW), .TMO_W(TMO_W), .BLANK_W(BLANK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_a_out(cpu_a_out), .cpu_b_out(cpu_b_out),
    .timeout_cycles(timeout_cycles), .blank_cycles(blank_cycles),
    .sanity_pass(sanity_pass), .sanity_fail(sanity_fail), .manual_restart(manual_restart),
    .run_en(run_en), .sanity_start(sanity_start), .sel_cpu(sel_cpu), .sel_bus(sel_bus),
    .sel_mem(sel_mem), .all_failed(all_failed), .combo_idx(combo_idx), .seq_state(seq_state));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";
  bit started = 0;

  // reference model
  int m_state = 0, m_pos = 0, m_tried = 0, m_tmo = 0, m_blank = 0;

  function automatic int gray(int p);
    return p ^ (p >> 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_pos = 0; m_tried = 0; m_tmo = 0; m_blank = 0;
    end else begin
      case (m_state)
        0: if (m_blank > 0) m_blank--;
           else if (cpu_a_out != cpu_b_out) begin m_state = 1; m_pos = (m_pos + 1) % 8; m_tried = 1; end
        1: begin m_state = 2; m_tmo = 0; end
        2: begin
          int tt;
          tt = (timeout_cycles == 0) ? 1 : int'(timeout_cycles);
          if (sanity_pass) begin m_state = 0; m_blank = int'(blank_cycles); end
          else if (sanity_fail || (m_tmo + 1 >= tt)) begin
            if (m_tried == 8) m_state = 3;
            else begin m_state = 1; m_pos = (m_pos + 1) % 8; m_tried++; end
          end else m_tmo++;
        end
        default: if (manual_restart) begin m_state = 1; m_pos = (m_pos + 1) % 8; m_tried = 1; end
      endcase
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (started && rst_n) begin
      chk(cur_req, "seq_state", int'(seq_state), m_state);
      chk(cur_req, "combo_idx", int'(combo_idx), m_pos);
      chk(cur_req, "selects", int'({sel_mem, sel_bus, sel_cpu}), gray(m_pos));
      chk(cur_req, "run_en", int'(run_en), int'(m_state == 0));
      chk(cur_req, "sanity_start", int'(sanity_start), int'(m_state == 1));
      chk(cur_req, "all_failed", int'(all_failed), int'(m_state == 3));
    end
  end

  // sanity test responder: 0 none (timeout), 1 fail, 2 pass, 3 both
  int plan[$];
  int cur_resp = 0;
  always @(negedge clk) begin
    if (seq_state == 2'd2) begin
      sanity_pass = (cur_resp == 2 || cur_resp == 3);
      sanity_fail = (cur_resp == 1 || cur_resp == 3);
    end else begin
      sanity_pass = 1'b0;
      sanity_fail = 1'b0;
    end
    if (sanity_start) cur_resp = (plan.size() > 0) ? plan.pop_front() : 0;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    while (cycles < 100000) @(negedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    finish_run();
  end

  task automatic wait_state(int s);
    for (int i = 0; i < 500; i++) begin
      if (int'(seq_state) == s) return;
      @(negedge clk);
    end
  endtask

  task automatic pulse_mismatch();
    @(negedge clk);
    cpu_b_out = cpu_a_out ^ 32'h0000_0100;
    @(negedge clk);
    cpu_b_out = cpu_a_out;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base, runs;
    cpu_a_out = 32'hA5A5_0001; cpu_b_out = 32'hA5A5_0001;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1;
    // R1 reset state
    chk("R1", "state after reset", int'(seq_state), 0);
    chk("R1", "selects after reset", int'({sel_mem, sel_bus, sel_cpu}), 0);
    chk("R1", "run_en after reset", int'(run_en), 1);
    idle(4);

    // R10 restart outside isolate
    cur_req = "R10";
    @(negedge clk); manual_restart = 1'b1;
    @(negedge clk); manual_restart = 1'b0;
    @(negedge clk);
    chk("R10", "restart in run ignored", int'(seq_state), 0);

    // R2 R3 R6 R5: two fails then pass
    cur_req = "R2";
    plan = '{1, 1, 2};
    pulse_mismatch();
    chk("R2", "state after mismatch", int'(seq_state), 1);
    cur_req = "R6";
    @(negedge clk);
    wait_state(0);
    cur_req = "R5";
    chk("R5", "combo after third trial", int'(combo_idx), 3);
    chk("R3", "gray selects of combo 3", int'({sel_mem, sel_bus, sel_cpu}), 2);
    idle(8);

    // R9 blanking window with held mismatch, R10 mismatch during wait
    cur_req = "R9";
    plan = '{2, 2};
    cpu_b_out = ~cpu_a_out;
    wait_state(1);
    cur_req = "R10";
    wait_state(0);
    cur_req = "R9";
    runs = 0;
    while (seq_state == 2'd0 && runs < 50) begin runs++; @(negedge clk); end
    chk("R9", "run cycles before blanked mismatch acts", runs, int'(blank_cycles) + 1);
    cpu_b_out = cpu_a_out;
    wait_state(0);
    idle(8);

    // R6 timeouts
    cur_req = "R6";
    timeout_cycles = 16'd3;
    plan = '{0, 0, 2};
    base = int'(combo_idx);
    pulse_mismatch();
    wait_state(2);
    runs = 0;
    while (seq_state == 2'd2 && runs < 50) begin runs++; @(negedge clk); end
    chk("R6", "wait cycles before timeout", runs, 3);
    wait_state(0);
    chk("R6", "combo after two timeouts", int'(combo_idx), (base + 3) % 8);
    idle(8);

    // R6 timeout limit of zero
    timeout_cycles = 16'd0;
    plan = '{0, 2};
    pulse_mismatch();
    wait_state(2);
    runs = 0;
    while (seq_state == 2'd2 && runs < 50) begin runs++; @(negedge clk); end
    chk("R6", "zero limit waits one cycle", runs, 1);
    wait_state(0);
    timeout_cycles = 16'd5;
    idle(8);

    // R5 pass and fail together
    cur_req = "R5";
    plan = '{3};
    base = int'(combo_idx);
    pulse_mismatch();
    wait_state(0);
    chk("R5", "pass wins over fail", int'(combo_idx), (base + 1) % 8);
    idle(8);

    // R7 all fail, R8 restart
    cur_req = "R7";
    plan = '{1, 1, 1, 1, 1, 1, 1, 1};
    base = int'(combo_idx);
    pulse_mismatch();
    wait_state(3);
    chk("R7", "isolate reached", int'(seq_state), 3);
    chk("R7", "alarm high", int'(all_failed), 1);
    chk("R7", "combo back at origin", int'(combo_idx), base);
    cur_req = "R8";
    cpu_b_out = ~cpu_a_out;
    idle(6);
    chk("R8", "isolate holds", int'(seq_state), 3);
    cpu_b_out = cpu_a_out;
    plan = '{2};
    @(negedge clk); manual_restart = 1'b1;
    @(negedge clk); manual_restart = 1'b0;
    chk("R8", "alarm cleared", int'(all_failed), 0);
    wait_state(0);
    chk("R8", "restart next combo", int'(combo_idx), (base + 1) % 8);
    idle(8);

    finish_run();
  end
endmodule